// File: doc/BRIEF.md
# Serial CRC7 and CRC16 tracker

This block follows a serial bit stream one bit at a time and keeps two running checksums of it at once: the 7-bit CRC that protects card commands and the 16-bit CRC that protects data blocks. Either the bits being sent to the card or the bits coming back from it feed both checksums. A direction input chooses the stream. The neighbouring shift engine pulses a bit strobe for every bit it actually moves. Bits that no strobe marks never reach the checksums.

Before a command or a data block, software pulses a clear input, which returns both checksums to zero. After the last bit, software reads two 16-bit values. The 7-bit result comes already placed as a closing command byte, with the checksum above a stop bit of 1. The 16-bit result comes as it is. Both checksums use the generator polynomials common to memory cards, start from zero and take the most significant bit first.

Top module: `crc_tracker`

## Requirements
- R1: After reset, crc7Read is 16'h0001 and crc16Read is 16'h0000.
- R2: A cycle with clearStb high and bitStrobe low makes crc7Read 16'h0001 and crc16Read 16'h0000 on the following cycle.
- R3: With dirTx = 1, the bit taken at each strobe is txBit, and rxBit has no effect on either result.
- R4: With dirTx = 0, the bit taken at each strobe is rxBit, and txBit has no effect on either result.
- R5: crc7Read holds the 7-bit checksum in bits 7..1, a constant 1 in bit 0 and zeros in bits 15..8.
- R6: crc16Read holds the full 16-bit checksum, bit 15 being the coefficient of x^15.
- R7: In a cycle with neither bitStrobe nor clearStb high, both results keep their value, whatever the data and direction inputs do.
- R8: clearStb and bitStrobe high in the same cycle give the checksum of that single bit, fed from zero. A 1 gives crc7Read 16'h0013 and crc16Read 16'h1021. A 0 gives 16'h0001 and 16'h0000.
- R9: The 7-bit checksum uses x^7+x^3+1 and the 16-bit checksum uses x^16+x^12+x^5+1, both fed MSB first from zero. The five command bytes 40 00 00 00 00 give crc7Read 16'h0095. 512 bytes of FF give crc16Read 16'h7FA1.
- R10: Each cycle with bitStrobe high advances both checksums by exactly one bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bitStrobe | input | 1 | One bit of the selected stream is valid in this cycle |
| txBit | input | 1 | Bit being shifted out to the card |
| rxBit | input | 1 | Bit being shifted in from the card |
| dirTx | input | 1 | 1 selects txBit, 0 selects rxBit |
| clearStb | input | 1 | Clears both checksums |
| crc7Read | output | 16 | Framed 7-bit checksum read value |
| crc16Read | output | 16 | 16-bit checksum read value |

## Verification
Both checksums sit in registers that read straight out to the ports. A strobe or clear applied in one cycle therefore shows in the read values one clock edge later, with no further delay. The bench drives each input on a falling edge and compares on the next falling edge, after the single rising edge that takes the stimulus. Hold checks span several idle cycles with the data and direction inputs toggling. The expected values come from a bitwise polynomial division in the bench and from fixed command and data-block vectors.

// File: rtl/crc_tracker_pkg.sv
package crc_tracker_pkg;

  // Strobes handed from the control side to the datapath.
  typedef struct packed {
    logic clear;    // restart both checksums from zero
    logic advance;  // absorb dataBit this cycle
    logic dataBit;  // bit of the selected stream
  } crcStrobes_t;

endpackage

// File: rtl/crc_serial_lfsr.sv
module crc_serial_lfsr #(
  parameter int WIDTH = 7,
  parameter logic [WIDTH-1:0] POLY = 7'h09
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic             advance,
  input  logic             dataBit,
  output logic [WIDTH-1:0] crc
);

  logic [WIDTH-1:0] baseVal;
  logic [WIDTH-1:0] nextVal;
  logic             feedback;

  // A clear in the same cycle restarts from zero before the bit goes in.
  always_comb begin
    baseVal  = clear ? '0 : crc;
    feedback = dataBit ^ baseVal[WIDTH-1];
    if (advance)
      nextVal = {baseVal[WIDTH-2:0], 1'b0} ^ (feedback ? POLY : '0);
    else
      nextVal = baseVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      crc <= '0;
    else if (clear || advance)
      crc <= nextVal;
  end

endmodule

// File: rtl/crc_tracker_ctrl.sv
module crc_tracker_ctrl
  import crc_tracker_pkg::*;
(
  input  logic        bitStrobe,
  input  logic        txBit,
  input  logic        rxBit,
  input  logic        dirTx,
  input  logic        clearStb,
  output crcStrobes_t strobes
);

  always_comb begin
    strobes.clear   = clearStb;
    strobes.advance = bitStrobe;
    strobes.dataBit = dirTx ? txBit : rxBit;
  end

endmodule

// File: rtl/crc_tracker_dp.sv
module crc_tracker_dp
  import crc_tracker_pkg::*;
#(
  parameter int C7_WIDTH  = 7,
  parameter logic [C7_WIDTH-1:0] C7_POLY = 7'h09,
  parameter int C16_WIDTH = 16,
  parameter logic [C16_WIDTH-1:0] C16_POLY = 16'h1021,
  parameter int READ_WIDTH = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  crcStrobes_t           strobes,
  output logic [READ_WIDTH-1:0] crc7Read,
  output logic [READ_WIDTH-1:0] crc16Read
);

  localparam int C7_FRAMED = C7_WIDTH + 1;
  localparam int C7_PAD    = READ_WIDTH - C7_FRAMED;
  localparam int C16_PAD   = READ_WIDTH - C16_WIDTH;

  logic [C7_WIDTH-1:0]  crc7Acc;
  logic [C16_WIDTH-1:0] crc16Acc;

  crc_serial_lfsr #(.WIDTH(C7_WIDTH), .POLY(C7_POLY)) u_crc7 (
    .clk     (clk),
    .rstN    (rstN),
    .clear   (strobes.clear),
    .advance (strobes.advance),
    .dataBit (strobes.dataBit),
    .crc     (crc7Acc)
  );

  crc_serial_lfsr #(.WIDTH(C16_WIDTH), .POLY(C16_POLY)) u_crc16 (
    .clk     (clk),
    .rstN    (rstN),
    .clear   (strobes.clear),
    .advance (strobes.advance),
    .dataBit (strobes.dataBit),
    .crc     (crc16Acc)
  );

  // Framed command end byte: checksum over a stop bit of 1.
  generate
    if (C7_PAD > 0) begin : g_c7_pad
      assign crc7Read = {{C7_PAD{1'b0}}, crc7Acc, 1'b1};
    end else begin : g_c7_full
      assign crc7Read = {crc7Acc, 1'b1};
    end
    if (C16_PAD > 0) begin : g_c16_pad
      assign crc16Read = {{C16_PAD{1'b0}}, crc16Acc};
    end else begin : g_c16_full
      assign crc16Read = crc16Acc;
    end
  endgenerate

endmodule

// File: rtl/crc_tracker.sv
module crc_tracker
  import crc_tracker_pkg::*;
#(
  parameter int C7_WIDTH  = 7,
  parameter logic [C7_WIDTH-1:0] C7_POLY = 7'h09,
  parameter int C16_WIDTH = 16,
  parameter logic [C16_WIDTH-1:0] C16_POLY = 16'h1021,
  parameter int READ_WIDTH = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  bitStrobe,
  input  logic                  txBit,
  input  logic                  rxBit,
  input  logic                  dirTx,
  input  logic                  clearStb,
  output logic [READ_WIDTH-1:0] crc7Read,
  output logic [READ_WIDTH-1:0] crc16Read
);

  crcStrobes_t strobes;

  crc_tracker_ctrl u_ctrl (
    .bitStrobe (bitStrobe),
    .txBit     (txBit),
    .rxBit     (rxBit),
    .dirTx     (dirTx),
    .clearStb  (clearStb),
    .strobes   (strobes)
  );

  crc_tracker_dp #(
    .C7_WIDTH   (C7_WIDTH),
    .C7_POLY    (C7_POLY),
    .C16_WIDTH  (C16_WIDTH),
    .C16_POLY   (C16_POLY),
    .READ_WIDTH (READ_WIDTH)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .crc7Read  (crc7Read),
    .crc16Read (crc16Read)
  );

endmodule

// File: rtl/crc_tracker_chk.sv
module crc_tracker_chk (
  input logic        clk,
  input logic        rstN,
  input logic        bitStrobe,
  input logic        txBit,
  input logic        rxBit,
  input logic        dirTx,
  input logic        clearStb,
  input logic [15:0] crc7Read,
  input logic [15:0] crc16Read
);

  logic selBit;
  assign selBit = dirTx ? txBit : rxBit;

  // R7: no strobe and no clear leaves both results unchanged
  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!bitStrobe && !clearStb) |=> ($stable(crc7Read) && $stable(crc16Read)));

  // R2: a lone clear returns both checksums to zero
  p_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    (clearStb && !bitStrobe) |=> (crc7Read == 16'h0001 && crc16Read == 16'h0000));

  // R5: framing of the 7-bit read value
  p_frame_r5: assert property (@(posedge clk) disable iff (!rstN)
    (crc7Read[0] == 1'b1 && crc7Read[15:8] == 8'h00));

  // R8: clear with a 1 bit in the same cycle
  p_clear_one_r8: assert property (@(posedge clk) disable iff (!rstN)
    (clearStb && bitStrobe && selBit) |=> (crc7Read == 16'h0013 && crc16Read == 16'h1021));

  // R8: clear with a 0 bit in the same cycle
  p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (clearStb && bitStrobe && !selBit) |=> (crc7Read == 16'h0001 && crc16Read == 16'h0000));

endmodule

bind crc_tracker crc_tracker_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .bitStrobe (bitStrobe),
  .txBit     (txBit),
  .rxBit     (rxBit),
  .dirTx     (dirTx),
  .clearStb  (clearStb),
  .crc7Read  (crc7Read),
  .crc16Read (crc16Read)
);

// File: tb/sim_crc_tracker.sv
`timescale 1ns/1ps
module sim_crc_tracker;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bitStrobe = 1'b0;
  logic        txBit = 1'b0;
  logic        rxBit = 1'b0;
  logic        dirTx = 1'b1;
  logic        clearStb = 1'b0;
  logic [15:0] crc7Read;
  logic [15:0] crc16Read;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [6:0]  ref7;
  logic [15:0] ref16;

  always #2.5 clk = ~clk;

  crc_tracker u0 (
    .clk(clk), .rstN(rstN), .bitStrobe(bitStrobe), .txBit(txBit),
    .rxBit(rxBit), .dirTx(dirTx), .clearStb(clearStb),
    .crc7Read(crc7Read), .crc16Read(crc16Read)
  );

  // Polynomial division one bit at a time, from the requirement text.
  function automatic logic [6:0] div7(input logic [6:0] c, input logic b);
    logic f;
    f = b ^ c[6];
    return {c[5:0], 1'b0} ^ (f ? 7'b0001001 : 7'b0);
  endfunction

  function automatic logic [15:0] div16(input logic [15:0] c, input logic b);
    logic f;
    f = b ^ c[15];
    return {c[14:0], 1'b0} ^ (f ? 16'b0001_0000_0010_0001 : 16'b0);
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkBoth(input string req);
    check(req, crc7Read, {8'h00, ref7, 1'b1});
    check(req, crc16Read, ref16);
  endtask

  // Clear pulse alone, then idle.
  task automatic doClear();
    @(negedge clk);
    clearStb = 1'b1; bitStrobe = 1'b0;
    @(negedge clk);
    clearStb = 1'b0;
    ref7 = '0; ref16 = '0;
  endtask

  // Shift one byte MSB first on the chosen channel; the other channel carries noise.
  task automatic sendByte(input logic [7:0] v, input logic useTx, input logic [7:0] noise);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk);
      dirTx = useTx; bitStrobe = 1'b1;
      if (useTx) begin txBit = v[i]; rxBit = noise[i]; end
      else       begin rxBit = v[i]; txBit = noise[i]; end
      ref7  = div7(ref7, v[i]);
      ref16 = div16(ref16, v[i]);
    end
    @(negedge clk);
    bitStrobe = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    ref7 = '0; ref16 = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", crc7Read, 16'h0001);
    check("R1", crc16Read, 16'h0000);

    // R3, R5, R6, R10: sweep all bytes on the transmit channel, rx carries the complement
    for (int v = 0; v < 256; v++) begin
      doClear();
      sendByte(v[7:0], 1'b1, ~v[7:0]);
      checkBoth("R3");
    end

    // R4: sweep all bytes on the receive channel, tx carries other noise
    for (int v = 0; v < 256; v++) begin
      doClear();
      sendByte(v[7:0], 1'b0, v[7:0] ^ 8'h5A);
      checkBoth("R4");
    end

    // R10: a longer stream accumulates one bit per strobe
    doClear();
    for (int v = 0; v < 16; v++) sendByte(8'(v * 37 + 11), v[0], 8'hC3);
    checkBoth("R10");

    // R7: idle cycles with toggling data and direction leave results alone
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      txBit = k[0]; rxBit = ~k[0]; dirTx = k[1];
    end
    @(negedge clk);
    checkBoth("R7");

    // R2: a lone clear zeroes both
    doClear();
    check("R2", crc7Read, 16'h0001);
    check("R2", crc16Read, 16'h0000);

    // R8: clear together with a 1 bit, after non-zero content
    sendByte(8'hA7, 1'b1, 8'h00);
    @(negedge clk);
    clearStb = 1'b1; bitStrobe = 1'b1; dirTx = 1'b0; rxBit = 1'b1; txBit = 1'b0;
    @(negedge clk);
    clearStb = 1'b0; bitStrobe = 1'b0;
    check("R8", crc7Read, 16'h0013);
    check("R8", crc16Read, 16'h1021);
    // R8: clear together with a 0 bit
    @(negedge clk);
    clearStb = 1'b1; bitStrobe = 1'b1; dirTx = 1'b1; txBit = 1'b0; rxBit = 1'b1;
    @(negedge clk);
    clearStb = 1'b0; bitStrobe = 1'b0;
    check("R8", crc7Read, 16'h0001);
    check("R8", crc16Read, 16'h0000);

    // R9: command vector gives closing byte 95
    doClear();
    sendByte(8'h40, 1'b1, 8'hFF);
    for (int k = 0; k < 4; k++) sendByte(8'h00, 1'b1, 8'hFF);
    check("R9", crc7Read, 16'h0095);

    // R9: 512 bytes of FF on the receive channel
    doClear();
    for (int k = 0; k < 512; k++) sendByte(8'hFF, 1'b0, 8'h00);
    check("R9", crc16Read, 16'h7FA1);
    // R5: the 7-bit value keeps its framing with arbitrary content
    check("R5", {crc7Read[15:8], 7'b0, crc7Read[0]}, 16'h0001);

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule